// File: doc/BRIEF.md
# ADC Scan Controller Register Block

This block is the digital front end of a 12-bit successive-approximation converter that has up to sixteen analog inputs. Software uses a 16-bit register bus to choose a set of channels in a bitmask, pick an end-of-scan interrupt, and set a start bit. The block then visits each selected channel once. For each channel it asks an external converter port for a sample through a request/done handshake, and it keeps each returned code in that channel's own result register. When the last channel completes, the block clears the start bit and, if enabled, pulses an interrupt.

The block also runs a calibration handshake through a separate control word. Software sets a request bit. After a fixed number of cycles the block raises a ready flag, along with an error flag that a test input can force. Clearing the request bit clears both flags. After reset, no conversion begins until a settling interval has elapsed. A start written earlier than that stays pending.

Offsets are byte addresses on a 9-bit bus. Reads are combinational, and writes take effect at the clock edge that sees the write enable.

Top module: `adc_scan_regs`

## Requirements
- R1: After reset every register reads zero, `conv_req` and `scan_irq` are low, and the result registers hold zero.
- R2: `conv_req` stays low for the first SETTLE_CYCLES cycles after reset. A start bit written during that interval stays set, and the scan runs once the interval ends.
- R3: A scan visits the channels whose bit is set in the channel mask (offset 0x04, bit n = channel n), in ascending index order, each channel once. The next selected channel is requested in the cycle right after the previous one completes, so unselected channels cost no cycles.
- R4: A channel completes on the first cycle in which `conv_done` is high and `conv_req` has been held for that channel for at least CONV_CYCLES cycles. A done that arrives earlier has no effect.
- R5: Completing channel n stores `conv_data` in the low 12 bits of the result register at offset 0x20 + 2*n; the upper 4 bits read zero. The result registers of unselected channels keep their values.
- R6: In the control word at offset 0x00, bit 15 is start, bits 14:13 are mode and bit 12 is interrupt enable. When the last selected channel completes, bit 15 clears. `scan_irq` then pulses high for exactly one cycle, and only if bit 12 was set.
- R7: A start with an all-zero mask clears bit 15 without any request or interrupt, and no result register changes.
- R8: A write to offset 0x00 with bit 15 low during a scan aborts it. `conv_req` falls in the next cycle, no further channels are requested and no interrupt is raised.
- R9: At offset 0x1F0, bit 0 requests calibration. Bit 1 (ready) rises CAL_CYCLES cycles after the request. Bit 2 (error) then takes the level of `cal_fail`. Writing bit 0 low clears bits 1 and 2.
- R10: While calibration runs (bit 0 set, bit 1 clear), writes to the start bit are ignored.
- R11: A scan is launched only when mode bits 14:13 are 00. With any other mode the start bit stays set and no request is made.
- R12: Reads of any offset other than 0x00, 0x04, 0x1F0 and the even result offsets of existing channels return zero. Unused bits of the mapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 9 | Byte offset of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| conv_req | output | 1 | Converter request, held while a channel is in progress |
| conv_chan | output | 4 | Channel index being converted |
| conv_done | input | 1 | Converter has a valid sample |
| conv_data | input | 12 | Sample code from the converter |
| cal_fail | input | 1 | Test input that forces the calibration error flag |
| scan_irq | output | 1 | One-cycle end-of-scan interrupt |

## Verification
The bench runs scans with sparse, dense, single-channel and empty masks, and it varies converter latency both below and above the minimum conversion time. A design that stepped through unselected channels would show extra visits or longer gaps, and one that took an early done would record a per-channel time shorter than CONV_CYCLES. Other directed cases cover an abort in the middle of a scan, a start written before settling or during calibration, and a non-single mode. In those cases a faulty block would go on requesting, raise a stray interrupt or start converting when it should not. Result registers are compared with a bench-side copy after every scan, so a wrong index, a write to an unselected channel or a missing write shows up as a data mismatch.

// File: rtl/adc_scan_regs.sv
module adc_scan_regs #(
  parameter int NCH           = 16,
  parameter int DW            = 12,
  parameter int AW            = 9,
  parameter int SETTLE_CYCLES = 50,
  parameter int CONV_CYCLES   = 32,
  parameter int CAL_CYCLES    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          conv_req,
  output logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] conv_chan,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          cal_fail,
  output logic          scan_irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam int VW = $clog2(CONV_CYCLES + 1);
  localparam int KW = $clog2(CAL_CYCLES + 1);
  localparam logic [AW-1:0] OFF_CSR  = AW'(16'h000);
  localparam logic [AW-1:0] OFF_MASK = AW'(16'h004);
  localparam logic [AW-1:0] OFF_RES  = AW'(16'h020);
  localparam logic [AW-1:0] OFF_CAL  = AW'(16'h1F0);
  localparam logic [AW-1:0] RES_END  = AW'(32'h20 + 2 * NCH);

  logic           start_q, ie_q, busy_q, irq_q;
  logic [1:0]     mode_q;
  logic [NCH-1:0] mask_q, pend_q, pend_next;
  logic [VW-1:0]  cnt_q;
  logic [SW-1:0]  settle_q;
  logic           cal_req_q, cal_rdy_q, cal_err_q;
  logic [KW-1:0]  cal_cnt_q;
  logic [DW-1:0]  res_q [NCH];
  logic [CW-1:0]  chan;

  wire wr_csr   = bus_we && bus_addr == OFF_CSR;
  wire wr_mask  = bus_we && bus_addr == OFF_MASK;
  wire wr_cal   = bus_we && bus_addr == OFF_CAL;
  wire cal_busy = cal_req_q && !cal_rdy_q;
  wire settled  = settle_q == SW'(SETTLE_CYCLES);
  wire launch   = start_q && !busy_q && settled && mode_q == 2'b00;
  wire accept   = busy_q && conv_done && cnt_q == VW'(CONV_CYCLES - 1);
  wire abort    = wr_csr && !cal_busy && !bus_wdata[15];
  wire last     = accept && pend_next == '0;

  always_comb begin
    chan = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) chan = CW'(i);
  end

  assign pend_next = pend_q & ~(NCH'(1) << chan);
  assign conv_req  = busy_q;
  assign conv_chan = chan;
  assign scan_irq  = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (!settled) begin
      settle_q <= settle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      ie_q    <= 1'b0;
      mode_q  <= 2'b00;
      mask_q  <= '0;
    end else begin
      if (wr_csr) begin
        ie_q   <= bus_wdata[12];
        mode_q <= bus_wdata[14:13];
      end
      if (wr_mask) mask_q <= bus_wdata[NCH-1:0];
      if (wr_csr && !cal_busy) start_q <= bus_wdata[15];
      else if (launch && mask_q == '0) start_q <= 1'b0;
      else if (last) start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= last && ie_q && !abort;
      if (abort) begin
        busy_q <= 1'b0;
        pend_q <= '0;
      end else if (launch && mask_q != '0) begin
        busy_q <= 1'b1;
        pend_q <= mask_q;
        cnt_q  <= '0;
      end else if (accept) begin
        pend_q <= pend_next;
        cnt_q  <= '0;
        if (last) busy_q <= 1'b0;
      end else if (busy_q && cnt_q != VW'(CONV_CYCLES - 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) res_q[i] <= '0;
    end else if (accept) begin
      res_q[chan] <= conv_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_req_q <= 1'b0;
      cal_rdy_q <= 1'b0;
      cal_err_q <= 1'b0;
      cal_cnt_q <= '0;
    end else if (wr_cal) begin
      cal_req_q <= bus_wdata[0];
      if (!bus_wdata[0]) begin
        cal_rdy_q <= 1'b0;
        cal_err_q <= 1'b0;
        cal_cnt_q <= '0;
      end
    end else if (cal_busy) begin
      if (cal_cnt_q == KW'(CAL_CYCLES - 1)) begin
        cal_rdy_q <= 1'b1;
        cal_err_q <= cal_fail;
      end else begin
        cal_cnt_q <= cal_cnt_q + 1'b1;
      end
    end
  end

  wire           res_hit = !bus_addr[0] && bus_addr >= OFF_RES && bus_addr < RES_END;
  wire [AW-1:0]  res_off = bus_addr - OFF_RES;
  wire [CW-1:0]  res_idx = res_off[CW:1];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CSR)       bus_rdata = {start_q, mode_q, ie_q, 12'h000};
    else if (bus_addr == OFF_MASK) bus_rdata = 16'(mask_q);
    else if (bus_addr == OFF_CAL)  bus_rdata = {13'h0, cal_err_q, cal_rdy_q, cal_req_q};
    else if (res_hit)              bus_rdata = 16'(res_q[res_idx]);
  end
endmodule

module adc_scan_regs_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_req,
  input logic [CW-1:0] conv_chan,
  input logic          conv_done,
  input logic          scan_irq,
  input logic          start_q,
  input logic          ie_q,
  input logic          settled,
  input logic          cal_busy,
  input logic          cal_req_q,
  input logic          cal_rdy_q,
  input logic          cal_err_q
);
  AST_NO_REQ_BEFORE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> settled); // R2
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && $past(conv_req && !conv_done) |-> $stable(conv_chan)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |=> !scan_irq); // R6
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |-> $past(ie_q)); // R6
  AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> start_q); // R8
  AST_CAL_FLAGS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_req_q |-> !cal_rdy_q && !cal_err_q); // R9
  AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err_q |-> cal_rdy_q); // R9
  AST_START_IGNORED_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> !$past(cal_busy)); // R10
endmodule

bind adc_scan_regs adc_scan_regs_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_chan(conv_chan),
  .conv_done(conv_done), .scan_irq(scan_irq), .start_q(start_q), .ie_q(ie_q),
  .settled(settled), .cal_busy(cal_busy), .cal_req_q(cal_req_q),
  .cal_rdy_q(cal_rdy_q), .cal_err_q(cal_err_q)
);

// File: tb/adc_scan_regs_bench.sv
`timescale 1ns/1ps
module adc_scan_regs_bench;
  localparam int NCH = 16, SETTLE = 40, CONV = 6, CAL = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        conv_req, conv_done = 1'b0, cal_fail = 1'b0, scan_irq;
  logic [3:0]  conv_chan;
  logic [11:0] conv_data = '0;

  adc_scan_regs #(.NCH(NCH), .SETTLE_CYCLES(SETTLE), .CONV_CYCLES(CONV),
                  .CAL_CYCLES(CAL)) u_adc_scan_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_req(conv_req),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .cal_fail(cal_fail), .scan_irq(scan_irq));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, early_req = 0, irq_cnt = 0, tag = 0, lat = 1, age = 0;
  int log_len = 0;
  int log_ch [32];
  int log_cyc [32];
  int exp_res [NCH];
  logic prev_req = 1'b0;
  logic [3:0] prev_chan = '0;

  function automatic logic [11:0] data_of(int ch, int t);
    return 12'((ch * 257 + t * 91 + 53) & 12'hFFF);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (conv_req && cyc < SETTLE) early_req++;
      if (scan_irq) irq_cnt++;
      if (conv_req && prev_req && conv_chan == prev_chan) age++;
      else if (conv_req) age = 1;
      else age = 0;
      if (conv_req && (!prev_req || conv_chan != prev_chan)) begin
        if (log_len < 32) begin
          log_ch[log_len] = int'(conv_chan);
          log_cyc[log_len] = 1;
        end
        log_len++;
      end else if (conv_req && log_len > 0 && log_len <= 32) begin
        log_cyc[log_len-1]++;
      end
      prev_req  = conv_req;
      prev_chan = conv_chan;
      conv_done = conv_req && age >= lat;
      conv_data = data_of(int'(conv_chan), tag);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_results(string req);
    logic [15:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(9'(32'h20 + 2 * c), d);
      check(d == 16'(exp_res[c]), req, int'(d), exp_res[c]);
    end
  endtask

  task automatic run_scan(logic [15:0] m, bit ie, int l);
    logic [15:0] d;
    int irq0, n, k, tmo;
    tag++;
    lat = l;
    log_len = 0;
    irq0 = irq_cnt;
    wr(9'h004, m);
    wr(9'h000, {1'b1, 2'b00, ie, 12'h000});
    tmo = 0;
    rd(9'h000, d);
    while (d[15] && tmo < 3000) begin
      idle(1);
      rd(9'h000, d);
      tmo++;
    end
    check(tmo < 3000, "R6 start clears", int'(d), 0);
    idle(3);
    n = $countones(m);
    check(log_len == n, "R3 visit count", log_len, n);
    k = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        if (k < log_len && k < 32) begin
          check(log_ch[k] == c, "R3 order", log_ch[k], c);
          check(log_cyc[k] == ((l > CONV) ? l : CONV), "R4 channel time",
                log_cyc[k], (l > CONV) ? l : CONV);
        end
        exp_res[c] = int'(data_of(c, tag));
        k++;
      end
    end
    if (m == 0)
      check(irq_cnt == irq0, "R7 no irq on empty mask", irq_cnt - irq0, 0);
    else
      check(irq_cnt - irq0 == int'(ie), "R6 irq count", irq_cnt - irq0, int'(ie));
    check_results(m == 0 ? "R7 results unchanged" : "R5 results");
  endtask

  initial begin
    #(10 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int n0, i0;
    void'($urandom(32'h5EED));
    for (int c = 0; c < NCH; c++) exp_res[c] = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    rd(9'h000, d); check(d == 0, "R1 csr", int'(d), 0);
    rd(9'h004, d); check(d == 0, "R1 mask", int'(d), 0);
    rd(9'h1F0, d); check(d == 0, "R1 cal", int'(d), 0);
    check(!conv_req && !scan_irq, "R1 outputs", int'({conv_req, scan_irq}), 0);
    check_results("R1 results");

    run_scan(16'h0005, 1'b1, 1);
    check(early_req == 0, "R2 no request before settle", early_req, 0);

    run_scan(16'h0000, 1'b1, 1);
    run_scan(16'h8001, 1'b1, 2);
    run_scan(16'hFFFF, 1'b0, CONV + 4);
    run_scan(16'h0400, 1'b1, CONV);
    for (int it = 0; it < 25; it++) begin
      logic [15:0] m;
      m = ($urandom % 6 == 0) ? 16'h0 : 16'($urandom);
      run_scan(m, 1'($urandom), 1 + int'($urandom % (CONV + 3)));
    end

    // R8 abort mid-scan
    lat = CONV + 30;
    log_len = 0;
    i0 = irq_cnt;
    wr(9'h004, 16'hFFFF);
    wr(9'h000, 16'h9000);
    idle(8);
    wr(9'h000, 16'h0000);
    idle(1);
    check(!conv_req, "R8 request drops", int'(conv_req), 0);
    n0 = log_len;
    idle(60);
    check(log_len == n0, "R8 no further channels", log_len, n0);
    check(irq_cnt == i0, "R8 no irq", irq_cnt - i0, 0);
    rd(9'h000, d); check(d == 0, "R8 start clear", int'(d), 0);
    check_results("R8 results unchanged");

    // R11 non-single mode
    lat = 1;
    log_len = 0;
    wr(9'h004, 16'h0001);
    wr(9'h000, 16'hA000);
    idle(30);
    check(log_len == 0, "R11 no request in other mode", log_len, 0);
    rd(9'h000, d); check(d == 16'hA000, "R11 start held", int'(d), 16'hA000);
    wr(9'h000, 16'h0000);

    // R12 readback and unmapped offsets
    wr(9'h000, 16'h6FFF);
    rd(9'h000, d); check(d == 16'h6000, "R12 csr unused bits", int'(d), 16'h6000);
    wr(9'h000, 16'h0000);
    rd(9'h002, d); check(d == 0, "R12 unmapped 0x02", int'(d), 0);
    rd(9'h006, d); check(d == 0, "R12 unmapped 0x06", int'(d), 0);
    rd(9'h021, d); check(d == 0, "R12 odd result offset", int'(d), 0);
    rd(9'h040, d); check(d == 0, "R12 past last result", int'(d), 0);
    rd(9'h1F2, d); check(d == 0, "R12 unmapped 0x1F2", int'(d), 0);
    rd(9'h100, d); check(d == 0, "R12 unmapped 0x100", int'(d), 0);

    // R9 calibration
    cal_fail = 1'b0;
    wr(9'h1F0, 16'h0001);
    idle(CAL / 2);
    rd(9'h1F0, d); check(d == 16'h1, "R9 cal in progress", int'(d), 1);
    idle(CAL);
    rd(9'h1F0, d); check(d == 16'h3, "R9 cal ready", int'(d), 3);
    wr(9'h1F0, 16'h0000);
    rd(9'h1F0, d); check(d == 0, "R9 cal clear", int'(d), 0);
    cal_fail = 1'b1;
    wr(9'h1F0, 16'h0001);
    idle(CAL + 4);
    rd(9'h1F0, d); check(d == 16'h7, "R9 cal error", int'(d), 7);
    wr(9'h1F0, 16'h0000);
    rd(9'h1F0, d); check(d == 0, "R9 error clear", int'(d), 0);
    cal_fail = 1'b0;

    // R10 start ignored during calibration
    log_len = 0;
    wr(9'h004, 16'h0003);
    wr(9'h1F0, 16'h0001);
    wr(9'h000, 16'h8000);
    rd(9'h000, d); check(d == 0, "R10 start ignored", int'(d), 0);
    idle(CAL + 4);
    check(log_len == 0, "R10 no scan", log_len, 0);
    wr(9'h1F0, 16'h0000);
    run_scan(16'h0003, 1'b1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule